// File: doc/BRIEF.md
# Persistent Register Store Sequencer with Busy Flag

This block owns the persistent setting registers of a dual digital potentiometer: four 6-bit slots for each of the two pots, eight in all. It models the persistent array as a register file whose updates take a programmable number of clock cycles. The command decoder hands it store requests of three kinds:
- a direct write of a host-supplied value into one slot;
- a save of one pot's current wiper value into one of that pot's slots;
- a save of both pots' wiper values into the slot with the same index on each pot.

A request is only held as pending while the frame is open (chip select low). It is committed when chip select returns high. At that moment the write-protect input is sampled, and a low level throws the pending request away. While a store runs, a busy flag is set. The flag appears as bit 0 of a status byte and also keeps the device out of standby. The slot contents stay readable through a read port all the time. During a store, that port still shows the value the slot had before the store.

Top module: `nvs_store_seq`

## Requirements
- R1: After reset, busy is 0, the status byte is 0x00, every slot reads 0, and `standbyOk` is 1 while `csN` is high.
- R2: A store request changes no slot before chip select rises. Busy is set in the first cycle after the clock edge at which `csN` is first sampled high following a low level, provided that a request is pending and `wpN` is high.
- R3: If `wpN` is low at the chip-select rise, the pending request is discarded. No busy cycle follows and no slot changes. A chip-select rise always clears the pending request.
- R4: A store keeps busy high for exactly `STORE_CYCLES` cycles. Bit 0 of `statusByte` equals busy, and bits 7:1 are always 0.
- R5: While busy is high, `rdData` returns the slot's value from before the store. The new value appears in the cycle in which busy falls.
- R6: `reqKind` encodes the request: 2'b01 is a direct write, 2'b10 is a single wiper save, and 2'b11 is a global save.
  - A single save stores the wiper value of pot `reqPot` into slot `reqIdx` of that pot. The wiper value is taken from `wiperIn[6*p +: 6]`, where p is the pot, and it is captured in the request cycle.
  - A direct write stores `reqData` into slot `reqIdx` of pot `reqPot`.
  - In both cases the other pot is unchanged.
- R7: A global save writes both pots' slot `reqIdx` in a single store cycle. Each pot receives its own wiper value captured at the request.
- R8: A request that arrives while busy is high is ignored. It leads to no store even when chip select rises after busy has fallen.
- R9: `standbyOk` is 1 only when `csN` is high and busy is 0. It is 0 during the whole store.
- R10: A request with `reqKind` 2'b00, or a request made while `csN` is high, is ignored. A chip-select rise that has no pending request starts no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, low while a frame is open |
| wpN | input | 1 | Write protect, low blocks stores |
| reqValid | input | 1 | One-cycle store request strobe from the command decoder |
| reqKind | input | 2 | Request kind: 01 direct write, 10 single save, 11 global save |
| reqPot | input | 1 | Target pot for direct write and single save |
| reqIdx | input | 2 | Target slot index |
| reqData | input | 6 | Value for a direct write |
| wiperIn | input | 12 | Current wiper values, pot p at bits 6p+5:6p |
| rdPot | input | 1 | Read port pot select |
| rdIdx | input | 2 | Read port slot select |
| rdData | output | 6 | Contents of the selected slot |
| statusByte | output | 8 | Status byte, bit 0 is the store-in-progress flag |
| standbyOk | output | 1 | High when the device may enter standby |

## Verification
The hardest situation to reach is a request that is accepted as a frame but arrives during a store. It must be dropped, and the drop can only be seen after busy ends and chip select rises. The stimulus opens a new frame right after a store begins, issues a write inside that frame, and holds chip select low until busy falls. It then closes the frame and checks that no second store starts and that the slot keeps its value. Random frames mix the request kinds, the protect levels and the wiper values, and the bench changes the wiper inputs after each request, so the snapshot timing and the protect discard are exercised many times.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int NV_POTS = 2;
  localparam int NV_REGS = 4;
  localparam int NV_DW   = 6;
  localparam int POT_W   = (NV_POTS > 1) ? $clog2(NV_POTS) : 1;
  localparam int IDX_W   = (NV_REGS > 1) ? $clog2(NV_REGS) : 1;
  localparam int STAT_W  = 8;

  typedef enum logic [1:0] {
    REQ_NONE        = 2'b00,
    REQ_DATA_WRITE  = 2'b01,
    REQ_WIPER_SAVE  = 2'b10,
    REQ_GLOBAL_SAVE = 2'b11
  } req_kind_e;

  typedef struct packed {
    logic                             busy;
    logic                             commit;
    logic [NV_POTS-1:0]               potMask;
    logic [IDX_W-1:0]                 idx;
    logic [NV_POTS-1:0][NV_DW-1:0]    data;
  } store_strobe_t;
endpackage

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int STORE_CYCLES = 1250
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      csN,
  input  logic                      wpN,
  input  logic                      reqValid,
  input  logic [1:0]                reqKind,
  input  logic [POT_W-1:0]          reqPot,
  input  logic [IDX_W-1:0]          reqIdx,
  input  logic [NV_DW-1:0]          reqData,
  input  logic [NV_POTS*NV_DW-1:0]  wiperIn,
  output store_strobe_t             strobe,
  output logic                      standbyOk
);
  localparam int CNT_W = $clog2(STORE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STORE_CYCLES - 1);

  req_kind_e kind;
  logic csQ, csRise, accept, busyQ;
  logic [CNT_W-1:0] cntQ;

  logic                          pendValid;
  logic [NV_POTS-1:0]            pendMask, actMask, reqMask;
  logic [IDX_W-1:0]              pendIdx, actIdx;
  logic [NV_POTS-1:0][NV_DW-1:0] pendData, actData, reqVals;

  assign kind   = req_kind_e'(reqKind);
  assign csRise = csN && !csQ;
  assign accept = reqValid && !csN && !busyQ && (kind != REQ_NONE);

  generate
    for (genvar p = 0; p < NV_POTS; p++) begin : g_req
      always_comb begin
        reqMask[p] = (kind == REQ_GLOBAL_SAVE) ||
                     ((kind != REQ_NONE) && (reqPot == POT_W'(p)));
        reqVals[p] = (kind == REQ_DATA_WRITE) ? reqData
                                              : wiperIn[p*NV_DW +: NV_DW];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ       <= 1'b1;
      pendValid <= 1'b0;
      pendMask  <= '0;
      pendIdx   <= '0;
      pendData  <= '0;
    end else begin
      csQ <= csN;
      if (csRise) begin
        pendValid <= 1'b0;
      end else if (accept) begin
        pendValid <= 1'b1;
        pendMask  <= reqMask;
        pendIdx   <= reqIdx;
        pendData  <= reqVals;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      cntQ    <= '0;
      actMask <= '0;
      actIdx  <= '0;
      actData <= '0;
    end else if (busyQ) begin
      if (cntQ == '0) begin
        busyQ <= 1'b0;
      end else begin
        cntQ <= cntQ - 1'b1;
      end
    end else if (csRise && pendValid && wpN) begin
      busyQ   <= 1'b1;
      cntQ    <= CNT_LAST;
      actMask <= pendMask;
      actIdx  <= pendIdx;
      actData <= pendData;
    end
  end

  always_comb begin
    strobe.busy    = busyQ;
    strobe.commit  = busyQ && (cntQ == '0);
    strobe.potMask = actMask;
    strobe.idx     = actIdx;
    strobe.data    = actData;
  end

  assign standbyOk = csN && !busyQ;
endmodule

// File: rtl/nvs_datapath.sv
module nvs_datapath
  import nvs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  store_strobe_t      strobe,
  input  logic [POT_W-1:0]   rdPot,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [NV_DW-1:0]   rdData,
  output logic [STAT_W-1:0]  statusByte
);
  logic [NV_DW-1:0] cells [NV_POTS][NV_REGS];

  generate
    for (genvar p = 0; p < NV_POTS; p++) begin : g_pot
      for (genvar r = 0; r < NV_REGS; r++) begin : g_slot
        always_ff @(posedge clk) begin
          if (!rstN) begin
            cells[p][r] <= '0;
          end else if (strobe.commit && strobe.potMask[p] &&
                       (strobe.idx == IDX_W'(r))) begin
            cells[p][r] <= strobe.data[p];
          end
        end
      end
    end
  endgenerate

  assign rdData     = cells[rdPot][rdIdx];
  assign statusByte = {{(STAT_W-1){1'b0}}, strobe.busy};
endmodule

// File: rtl/nvs_store_seq.sv
module nvs_store_seq
  import nvs_pkg::*;
#(
  parameter int STORE_CYCLES = 1250
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      csN,
  input  logic                      wpN,
  input  logic                      reqValid,
  input  logic [1:0]                reqKind,
  input  logic [POT_W-1:0]          reqPot,
  input  logic [IDX_W-1:0]          reqIdx,
  input  logic [NV_DW-1:0]          reqData,
  input  logic [NV_POTS*NV_DW-1:0]  wiperIn,
  input  logic [POT_W-1:0]          rdPot,
  input  logic [IDX_W-1:0]          rdIdx,
  output logic [NV_DW-1:0]          rdData,
  output logic [STAT_W-1:0]         statusByte,
  output logic                      standbyOk
);
  store_strobe_t strobe;

  nvs_ctrl #(.STORE_CYCLES(STORE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN),
    .reqValid(reqValid), .reqKind(reqKind), .reqPot(reqPot),
    .reqIdx(reqIdx), .reqData(reqData), .wiperIn(wiperIn),
    .strobe(strobe), .standbyOk(standbyOk)
  );

  nvs_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdPot(rdPot), .rdIdx(rdIdx), .rdData(rdData),
    .statusByte(statusByte)
  );
endmodule

// File: rtl/nvs_store_seq_chk.sv
module nvs_store_seq_chk
  import nvs_pkg::*;
#(
  parameter int STORE_CYCLES = 1250
) (
  input logic               clk,
  input logic               rstN,
  input logic               csN,
  input logic               wpN,
  input logic [POT_W-1:0]   rdPot,
  input logic [IDX_W-1:0]   rdIdx,
  input logic [NV_DW-1:0]   rdData,
  input logic [STAT_W-1:0]  statusByte,
  input logic               standbyOk
);
  localparam int CW = $clog2(STORE_CYCLES + 2);
  logic busy, csQ, csRiseC;
  logic [CW-1:0] busyCnt;

  assign busy    = statusByte[0];
  assign csRiseC = csN && !csQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ     <= 1'b1;
      busyCnt <= '0;
    end else begin
      csQ     <= csN;
      busyCnt <= busy ? busyCnt + 1'b1 : '0;
    end
  end

  a_r2_start_on_cs_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRiseC && wpN));

  a_r4_upper_status_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[STAT_W-1:1] == '0);

  a_r4_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < CW'(STORE_CYCLES)));

  a_r4_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(busyCnt) == CW'(STORE_CYCLES - 1)));

  a_r5_read_stable_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $stable(rdPot) && $stable(rdIdx)) |-> $stable(rdData));

  a_r9_no_standby_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !standbyOk);
endmodule

bind nvs_store_seq nvs_store_seq_chk #(.STORE_CYCLES(STORE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN),
  .rdPot(rdPot), .rdIdx(rdIdx), .rdData(rdData),
  .statusByte(statusByte), .standbyOk(standbyOk)
);

// File: tb/tb_nvs_store_seq.sv
module tb_nvs_store_seq;
  localparam int S = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wpN = 1'b1, reqValid = 1'b0;
  logic [1:0] reqKind = 2'b00;
  logic reqPot = 1'b0;
  logic [1:0] reqIdx = 2'b00, rdIdx = 2'b00;
  logic [5:0] reqData = '0, rdData;
  logic [11:0] wiperIn = '0;
  logic rdPot = 1'b0;
  logic [7:0] statusByte;
  logic standbyOk;

  int checks = 0, fails = 0;
  logic [5:0] expReg [2][4];

  always #4 clk = ~clk;

  nvs_store_seq #(.STORE_CYCLES(S)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN), .reqValid(reqValid),
    .reqKind(reqKind), .reqPot(reqPot), .reqIdx(reqIdx), .reqData(reqData),
    .wiperIn(wiperIn), .rdPot(rdPot), .rdIdx(rdIdx), .rdData(rdData),
    .statusByte(statusByte), .standbyOk(standbyOk)
  );

  function automatic logic [7:0] expStatus(input logic b);
    return {7'b0, b};
  endfunction

  function automatic logic expStores(input logic [1:0] k, input logic wp);
    return (k != 2'b00) && wp;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic readChk(input int p, input int r, input string req);
    rdPot = p[0]; rdIdx = r[1:0];
    #1;
    chk(rdData == expReg[p][r], req, rdData, expReg[p][r]);
  endtask

  task automatic allRegsChk(input string req);
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) readChk(p, r, req);
  endtask

  task automatic runFrame(input logic [1:0] k, input int p, input int r,
                          input logic [5:0] d, input logic wp, input logic [11:0] wip);
    logic st;
    int n;
    st = expStores(k, wp);
    @(negedge clk); csN = 1'b0; wiperIn = wip;
    @(negedge clk); reqValid = 1'b1; reqKind = k; reqPot = p[0]; reqIdx = r[1:0]; reqData = d;
    @(negedge clk); reqValid = 1'b0; wiperIn = ~wip; wpN = wp;
    readChk(p, r, "R2 no change before cs rise");
    @(negedge clk); csN = 1'b1;
    @(negedge clk);
    chk(statusByte[0] == st, st ? "R2 busy after cs rise" : "R3/R10 no store", statusByte[0], st);
    chk(statusByte == expStatus(st), "R4 status byte", statusByte, expStatus(st));
    chk(standbyOk == !st, "R9 standby", standbyOk, !st);
    readChk(p, r, "R5 old value while busy");
    n = 0;
    while (statusByte[0] && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == (st ? S : 0), "R4 busy length", n, st ? S : 0);
    if (st) begin
      case (k)
        2'b01: expReg[p][r] = d;
        2'b10: expReg[p][r] = wip[p*6 +: 6];
        default: begin
          expReg[0][r] = wip[5:0];
          expReg[1][r] = wip[11:6];
        end
      endcase
    end
    wpN = 1'b1;
    allRegsChk(k == 2'b11 ? "R7 global save" : (k == 2'b10 ? "R6 wiper save" : "R6 direct write"));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e));
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) expReg[p][r] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(statusByte == 8'h00, "R1 status after reset", statusByte, 0);
    chk(standbyOk == 1'b1, "R1 standby after reset", standbyOk, 1);
    allRegsChk("R1 slots zero after reset");

    // directed: each kind, both pots
    runFrame(2'b01, 1, 3, 6'h2a, 1'b1, 12'h000);
    runFrame(2'b10, 0, 2, 6'h00, 1'b1, 12'h7c5);
    runFrame(2'b11, 0, 1, 6'h00, 1'b1, 12'hfc1);
    runFrame(2'b01, 0, 0, 6'h3f, 1'b0, 12'h000);  // R3 protect
    runFrame(2'b00, 1, 1, 6'h11, 1'b1, 12'h000);  // R10 none kind

    // R10: request with csN high, then an empty frame
    @(negedge clk); reqValid = 1'b1; reqKind = 2'b01; reqPot = 1'b0; reqIdx = 2'd3; reqData = 6'h15;
    @(negedge clk); reqValid = 1'b0; csN = 1'b0;
    @(negedge clk); csN = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(statusByte[0] == 1'b0, "R10 request with cs high ignored", statusByte[0], 0);
    readChk(0, 3, "R10 slot unchanged");

    // R8: request during busy, frame closed after busy ends
    runFrame(2'b01, 1, 0, 6'h09, 1'b1, 12'h000);
    @(negedge clk); csN = 1'b0; wiperIn = 12'h000;
    @(negedge clk); reqValid = 1'b1; reqKind = 2'b01; reqPot = 1'b1; reqIdx = 2'd2; reqData = 6'h33;
    @(negedge clk); reqValid = 1'b0; csN = 1'b1;
    @(negedge clk); chk(statusByte[0] == 1'b1, "R8 setup store busy", statusByte[0], 1);
    csN = 1'b0;
    @(negedge clk); reqValid = 1'b1; reqKind = 2'b01; reqPot = 1'b0; reqIdx = 2'd2; reqData = 6'h2e;
    @(negedge clk); reqValid = 1'b0;
    while (statusByte[0]) @(negedge clk);
    expReg[1][2] = 6'h33;
    @(negedge clk); csN = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(statusByte[0] == 1'b0, "R8 request during busy ignored", statusByte[0], 0);
    allRegsChk("R8 slots unchanged");

    // random frames
    for (int i = 0; i < 40; i++) begin
      logic [1:0] k;
      k = 2'($urandom_range(0, 3));
      runFrame(k, int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
               6'($urandom), ($urandom_range(0, 4) != 0), 12'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule